// File: doc/BRIEF.md
# ADC Command Register Front End

This block sits on a simple single-cycle register bus in front of an ADC controller. Software uses it to hold configuration, interrupt status, interrupt mask and master control words. It also posts command words that do a no-op, a read or a write against a local bank of 16-bit converter registers. Every accepted command leaves one 16-bit result in a small readback FIFO inside the block. Software drains that FIFO by reading a dedicated word index.

Bus accesses take one cycle. `bus_sel` qualifies an access and `bus_wr` selects its direction. Read data is combinational from the current state, and register updates land on the next clock edge. The block has no valid/ready stream: the command path and the readback path are both plain register accesses. Back-pressure is therefore handled by rule rather than by handshake. A command that finds the FIFO full still acts on the register bank, but its result is dropped. A read of an empty FIFO returns zero and changes nothing.

Alarm and over-temperature pins feed sticky status bits. One level interrupt output reports any status bit whose mask bit is clear.

Top module: `adc_cmd_front`

## Requirements
- R1: After reset the word indices read back as follows: configuration (index 0) 0x00001814, interrupt status (index 1) 0x00000200, interrupt mask (index 2) 0xFFFFFFFF, master control (index 6) 0x00000010. Every converter register is zero.
- R2: The block ignores three kinds of access: any access to indices 7 and above, a write to index 3 or 5, and a read of index 4. Such a read returns zero, and such a write leaves the FIFO level and every register unchanged.
- R3: A write to index 4 is a command with opcode in bits 29:26, register address in bits 25:16 and data in bits 15:0. Opcode 1 (read) pushes the addressed register's value into the FIFO. Opcode 2 (write) stores the data in the addressed register and pushes zero. Opcode 0 (no-op) pushes zero.
- R4: While master control bit 4 is one, every command is discarded.
- R5: A read or write command whose address is 128 or more is discarded and does not touch the bank. A no-op with such an address is accepted. Opcodes above 2 are discarded.
- R6: A write to index 1 clears each status bit written as one. Bit 9 is set again on every cycle, so it always reads as one.
- R7: A write to index 2 stores only bits 9:0. Within those, bits 6:0 mask the alarms, bit 7 masks over-temperature, bit 8 masks the FIFO-above-threshold flag and bit 9 masks bit 9.
- R8: A write to index 6 stores the written value ANDed with 0x00FFFEFF.
- R9: Status bit 8 is set on each cycle in which the FIFO level is greater than configuration bits 19:16.
- R10: `irq` is high exactly when some status bit among 9:0 is one and its mask bit is zero.
- R11: A rising level on `alarm_in[i]` sets status bit i, and a rising level on `overtemp_in` sets bit 7. These bits stay set until software clears them. A clear while the input stays high does not set them again.
- R12: The FIFO holds 8 entries in arrival order. A read of index 5 returns the oldest entry in bits 15:0 and removes it. A push into a full FIFO is dropped. Index 3 reads: bit 10 set, level in bits 15:12, full in bit 9, empty in bit 8, live over-temperature in bit 7 and live alarms in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_idx | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| alarm_in | input | 7 | Alarm levels |
| overtemp_in | input | 1 | Over-temperature level |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a FIFO that sits at capacity, or above threshold, at the moment software clears the matching flag or posts a further command. Reaching it needs a precise count of pushes that the bus has no direct way to inject. The stimulus gets there in two ways. It fills the FIFO with exactly eight accepted commands and then posts a ninth. It also holds the level just at, and one above, a programmed threshold while it issues write-one-to-clear. The full sweep writes and reads back all 128 converter registers in batches of eight. Each batch drives the FIFO from empty to full and back.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam logic [2:0] IX_CFG  = 3'd0;
  localparam logic [2:0] IX_STS  = 3'd1;
  localparam logic [2:0] IX_MASK = 3'd2;
  localparam logic [2:0] IX_MISC = 3'd3;
  localparam logic [2:0] IX_CMD  = 3'd4;
  localparam logic [2:0] IX_RDF  = 3'd5;
  localparam logic [2:0] IX_MCTL = 3'd6;

  localparam logic [3:0] OPC_NOP = 4'd0;
  localparam logic [3:0] OPC_RD  = 4'd1;
  localparam logic [3:0] OPC_WR  = 4'd2;

  localparam logic [31:0] CFG_RST  = 32'h0000_1814;
  localparam logic [9:0]  STS_RST  = 10'h200;
  localparam logic [31:0] MCTL_RST = 32'h0000_0010;
  localparam logic [31:0] MCTL_WMSK = 32'h00FF_FEFF;
  localparam logic [31:0] MASK_WMSK = 32'h0000_03FF;
  localparam int HOLD_BIT = 4;
endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
  import adc_cmd_pkg::*;
#(
  parameter int NREGS = 128,
  localparam int AW = $clog2(NREGS)
) (
  input  logic [31:0]   word,
  input  logic          hold,
  output logic          ok,
  output logic          is_rd,
  output logic          is_wr,
  output logic [AW-1:0] addr,
  output logic [15:0]   data
);
  logic [3:0] opc;
  logic [9:0] fld;
  logic       in_range;
  logic       known;

  always_comb begin
    opc      = word[29:26];
    fld      = word[25:16];
    in_range = {22'b0, fld} < NREGS;
    known    = (opc == OPC_NOP) || (opc == OPC_RD) || (opc == OPC_WR);
    is_rd    = (opc == OPC_RD);
    is_wr    = (opc == OPC_WR);
    ok       = !hold && known && ((opc == OPC_NOP) || in_range);
    addr     = fld[AW-1:0];
    data     = word[15:0];
  end
endmodule

// File: rtl/adc_regbank.sv
module adc_regbank #(
  parameter int NREGS = 128,
  parameter int W = 16,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] bank [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[g] <= '0;
      else if (we && waddr == AW'(g))
        bank[g] <= wdata;
    end
  end

  assign rdata = bank[raddr];
endmodule

// File: rtl/adc_rb_fifo.sv
module adc_rb_fifo #(
  parameter int DEPTH = 8,
  parameter int W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [LW-1:0] level,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/adc_cmd_front.sv
module adc_cmd_front
  import adc_cmd_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(NREGS),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_idx,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [6:0]  alarm_in,
  input  logic        overtemp_in,
  output logic        irq
);
  logic [31:0] cfg_q, mask_q, mctl_q;
  logic [9:0]  sts_q, sts_d;
  logic [7:0]  evt_q, evt_now;
  logic        wr_en, rd_en;

  logic          cmd_ok, cmd_rd, cmd_wr;
  logic [AW-1:0] cmd_addr;
  logic [15:0]   cmd_data, bank_q;

  logic          fifo_pop, fifo_full, fifo_empty;
  logic [15:0]   fifo_head, fifo_din;
  logic [LW-1:0] level;

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign evt_now = {overtemp_in, alarm_in};

  adc_cmd_decode #(.NREGS(NREGS)) u_dec (
    .word  (bus_wdata),
    .hold  (mctl_q[HOLD_BIT]),
    .ok    (cmd_ok),
    .is_rd (cmd_rd),
    .is_wr (cmd_wr),
    .addr  (cmd_addr),
    .data  (cmd_data)
  );

  logic cmd_go;
  assign cmd_go = wr_en && (bus_idx == IX_CMD) && cmd_ok;

  adc_regbank #(.NREGS(NREGS), .W(16)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cmd_go && cmd_wr),
    .waddr (cmd_addr),
    .wdata (cmd_data),
    .raddr (cmd_addr),
    .rdata (bank_q)
  );

  assign fifo_din = cmd_rd ? bank_q : 16'h0000;
  assign fifo_pop = rd_en && (bus_idx == IX_RDF);

  adc_rb_fifo #(.DEPTH(DEPTH), .W(16)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cmd_go),
    .din   (fifo_din),
    .pop   (fifo_pop),
    .head  (fifo_head),
    .level (level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  always_comb begin
    sts_d = sts_q;
    if (wr_en && bus_idx == IX_STS) sts_d = sts_d & ~bus_wdata[9:0];
    sts_d[7:0] = sts_d[7:0] | (evt_now & ~evt_q);
    if (32'(level) > 32'(cfg_q[19:16])) sts_d[8] = 1'b1;
    sts_d[9] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      mask_q <= '1;
      mctl_q <= MCTL_RST;
      sts_q  <= STS_RST;
      evt_q  <= '0;
    end else begin
      sts_q <= sts_d;
      evt_q <= evt_now;
      if (wr_en) begin
        case (bus_idx)
          IX_CFG:  cfg_q  <= bus_wdata;
          IX_MASK: mask_q <= bus_wdata & MASK_WMSK;
          IX_MCTL: mctl_q <= bus_wdata & MCTL_WMSK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_idx)
        IX_CFG:  bus_rdata = cfg_q;
        IX_STS:  bus_rdata = {22'b0, sts_q};
        IX_MASK: bus_rdata = mask_q;
        IX_MISC: bus_rdata = 32'h0000_0400 | (32'(level) << 12) |
                             {22'b0, fifo_full, fifo_empty, evt_now};
        IX_RDF:  bus_rdata = {16'b0, fifo_head};
        IX_MCTL: bus_rdata = mctl_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(sts_q & ~mask_q[9:0]);
endmodule

// File: rtl/adc_cmd_front_chk.sv
module adc_cmd_front_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [2:0]    bus_idx,
  input logic [31:0]   bus_rdata,
  input logic [6:0]    alarm_in,
  input logic          overtemp_in,
  input logic [9:0]    sts,
  input logic [31:0]   mask,
  input logic [31:0]   mctl,
  input logic [LW-1:0] level
);
  p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_idx == 3'd4 && mctl[4]) |=> $stable(level));

  p_cfifo_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_idx == 3'd1) |-> bus_rdata[9]);

  p_mask_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_idx == 3'd2) |=> (mask[31:10] == 22'b0));

  p_mctl_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_idx == 3'd6) |=> (mctl[8] == 1'b0 && mctl[31:24] == 8'h00));

  p_alarm_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_in[0]) |=> sts[0]);

  p_ot_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overtemp_in) |=> sts[7]);

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);
endmodule

bind adc_cmd_front adc_cmd_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_idx     (bus_idx),
  .bus_rdata   (bus_rdata),
  .alarm_in    (alarm_in),
  .overtemp_in (overtemp_in),
  .sts         (sts_q),
  .mask        (mask_q),
  .mctl        (mctl_q),
  .level       (level)
);

// File: tb/tb_adc_cmd_front.sv
`timescale 1ns/1ps
module tb_adc_cmd_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_idx = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [6:0]  alarm_in = 7'd0;
  logic        overtemp_in = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_in(alarm_in), .overtemp_in(overtemp_in), .irq(irq)
  );

  function automatic logic [31:0] cmd(input logic [3:0] op, input int addr, input logic [15:0] d);
    return {2'b00, op, 10'(addr), d};
  endfunction

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 40503 + 4660) & 16'hFFFF);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] idx, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = idx;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    br(3'd0, v); check("R1 cfg", v, 32'h0000_1814);
    br(3'd1, v); check("R1 sts", v, 32'h0000_0200);
    br(3'd2, v); check("R1 mask", v, 32'hFFFF_FFFF);
    br(3'd6, v); check("R1 mctl", v, 32'h0000_0010);
    br(3'd3, v); check("R1 misc", v, 32'h0000_0500);
    check("R10 irq masked", {31'b0, irq}, 32'd0);

    // R4 command held off
    bw(3'd4, cmd(4'd0, 0, 16'h0));
    bw(3'd4, cmd(4'd2, 5, 16'hBEEF));
    br(3'd3, v); check("R4 no push while held", v, 32'h0000_0500);

    // R8 master control write masking
    bw(3'd6, 32'hFFFF_FFFF);
    br(3'd6, v); check("R8 mctl and", v, 32'h00FF_FEFF);
    bw(3'd6, 32'h0);
    br(3'd6, v); check("R8 mctl zero", v, 32'h0);

    // R2 ignored accesses
    br(3'd7, v); check("R2 undefined read", v, 32'h0);
    br(3'd4, v); check("R2 read of cmd", v, 32'h0);
    bw(3'd3, 32'hFFFF_FFFF);
    bw(3'd5, 32'hFFFF_FFFF);
    bw(3'd7, 32'hFFFF_FFFF);
    br(3'd3, v); check("R2 writes to ro", v, 32'h0000_0500);
    br(3'd0, v); check("R2 cfg untouched", v, 32'h0000_1814);

    // R3 / R12 full sweep of the bank in batches of DEPTH
    for (int b = 0; b < 16; b++) begin
      for (int k = 0; k < 8; k++) bw(3'd4, cmd(4'd2, b * 8 + k, pat(b * 8 + k)));
      br(3'd3, v); check("R12 misc full", v, 32'h0000_8600);
      for (int k = 0; k < 8; k++) begin
        br(3'd5, v); check("R3 write pushes zero", v, 32'h0);
      end
      for (int k = 0; k < 8; k++) bw(3'd4, cmd(4'd1, b * 8 + k, 16'h0));
      if (b == 15) bw(3'd4, cmd(4'd1, 0, 16'h0));
      for (int k = 0; k < 8; k++) begin
        br(3'd5, v); check("R3 read value", v, {16'b0, pat(b * 8 + k)});
      end
    end
    br(3'd5, v); check("R12 pop empty", v, 32'h0);
    br(3'd3, v); check("R12 empty after drop", v, 32'h0000_0500);

    // R5 out-of-range and unknown opcodes
    bw(3'd4, cmd(4'd1, 128, 16'h0));
    bw(3'd4, cmd(4'd2, 200, 16'h5A5A));
    bw(3'd4, cmd(4'd3, 0, 16'h0));
    br(3'd3, v); check("R5 discarded", v, 32'h0000_0500);
    bw(3'd4, cmd(4'd0, 1023, 16'h0));
    br(3'd3, v); check("R5 nop accepted", v, 32'h0000_1400);
    br(3'd5, v); check("R5 nop result", v, 32'h0);
    bw(3'd4, cmd(4'd1, 72, 16'h0));
    br(3'd5, v); check("R5 no alias write", v, {16'b0, pat(72)});

    // R6 / R9 threshold flag
    bw(3'd0, 32'h0002_1814);
    bw(3'd1, 32'hFFFF_FFFF);
    idle();
    br(3'd1, v); check("R6 bit9 stays", v, 32'h0000_0200);
    bw(3'd4, cmd(4'd0, 0, 16'h0));
    bw(3'd4, cmd(4'd0, 0, 16'h0));
    idle();
    br(3'd1, v); check("R9 level equal thr", v, 32'h0000_0200);
    bw(3'd4, cmd(4'd0, 0, 16'h0));
    idle(); idle();
    br(3'd1, v); check("R9 level above thr", v, 32'h0000_0300);
    bw(3'd1, 32'h0000_0100);
    idle();
    br(3'd1, v); check("R9 re-set while above", v, 32'h0000_0300);
    for (int k = 0; k < 3; k++) br(3'd5, v);
    idle();
    bw(3'd1, 32'h0000_0100);
    idle();
    br(3'd1, v); check("R6 clear sticks", v, 32'h0000_0200);

    // R7 mask width
    bw(3'd2, 32'hFFFF_FFFF);
    br(3'd2, v); check("R7 mask bits", v, 32'h0000_03FF);
    check("R10 irq low", {31'b0, irq}, 32'd0);

    // R10 interrupt on bit9
    bw(3'd2, 32'h0000_01FF);
    idle();
    check("R10 irq high", {31'b0, irq}, 32'd1);
    bw(3'd2, 32'h0000_03FF);
    idle();
    check("R10 irq low again", {31'b0, irq}, 32'd0);

    // R11 alarm and over-temperature edges
    @(negedge clk); alarm_in = 7'b000_1000;
    idle(); idle();
    br(3'd1, v); check("R11 alarm set", v, 32'h0000_0208);
    bw(3'd1, 32'h0000_0008);
    idle();
    br(3'd1, v); check("R11 held level no re-set", v, 32'h0000_0200);
    @(negedge clk); overtemp_in = 1'b1;
    idle(); idle();
    br(3'd1, v); check("R11 ot set", v, 32'h0000_0280);
    br(3'd3, v); check("R12 live inputs", v, 32'h0000_0588);
    bw(3'd2, 32'h0000_037F);
    idle();
    check("R10 irq from ot", {31'b0, irq}, 32'd1);
    bw(3'd1, 32'h0000_0080);
    idle();
    check("R10 irq after clear", {31'b0, irq}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule